// File: doc/BRIEF.md
# DMA Channel Request Gate and Stop Status

This block is the control and status slice of one DMA channel. Software programs it through a single control word: an enable bit that activates the channel, a pause bit that suspends it, a write-one software trigger and a write-one status clear. Hardware transfer requests and software triggers are checked against the channel state. An accepted request is offered to the data mover as a start command. The data mover reports back when the transfer completes or fails. The block records why the channel last stopped as a 3-bit code. It drives level interrupts for completion and for errors.

The start command is a valid/ready stream with no payload. Once `start_valid` rises, it stays high until the mover takes it with `start_ready`. Back-pressure only delays the start; it never loses or repeats it. While a start is being offered, or while a transfer is in flight, there is room for only one command. Any further request in that time is dropped, not queued. Control and status pins have no handshake.

Top module: `dmagate_chan`

## Requirements
- R1: After reset, `rd_data` reads all zeros. This includes the enable bit 0, the pause bit 1, the stop code in bits 6:4 (code 000) and the interrupt flags in bits 8 and 9. `irq_end`, `irq_err` and `start_valid` are low.
- R2: A one-cycle `hw_req` on an enabled, unpaused, idle channel raises `start_valid` in the next cycle. `start_valid` stays high while `start_ready` is low, and the start is accepted exactly once.
- R3: A request that arrives while pause (bit 1) is 1 is dropped. Clearing pause later does not start a transfer.
- R4: A control write with bit 2 set makes one request when the write completes. Bit 2 always reads back 0. A write with bit 2 clear makes no request.
- R5: A software trigger written while the channel is not enabled has no effect.
- R6: A software trigger in the same write that sets enable (bit 0) is valid, and the transfer starts.
- R7: A software trigger in the same write that sets pause is invalid. A later write that clears pause starts nothing.
- R8: A pause event records stop code 100 and raises no interrupt. A pause event is either setting pause on an enabled channel, or enabling the channel while pause is 1. In both cases no transfer starts.
- R9: `mv_done` during a transfer clears enable, records code 001 and raises `irq_end`.
- R10: `mv_addr_err` during a transfer records code 010. `mv_periph_err` records code 011. Each of these clears enable and raises `irq_err`.
- R11: When stop causes coincide, the code follows this priority: reset, then address error, then peripheral stop, then completion, then pause.
- R12: The interrupts are levels. They hold until a write with bit 0 (enable) or bit 3 (status clear) set. A write with neither bit leaves them set.
- R13: A request that arrives while a start is offered or a transfer is in flight is dropped, and it does not produce a later start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | DATA_W | Control word: bit 0 enable, bit 1 pause, bit 2 software trigger, bit 3 status clear |
| rd_data | output | DATA_W | Status word: bit 0 enable, bit 1 pause, bits 6:4 stop code, bit 8 end flag, bit 9 error flag |
| hw_req | input | 1 | Hardware transfer request, one cycle per request |
| start_valid | output | 1 | Start command offered to the data mover |
| start_ready | input | 1 | Data mover accepts the start command |
| mv_done | input | 1 | Data mover finished the programmed transfer |
| mv_addr_err | input | 1 | Data mover address overflow or underflow |
| mv_periph_err | input | 1 | Peripheral requested a stop |
| irq_end | output | 1 | Completion interrupt level |
| irq_err | output | 1 | Error interrupt level |

## Verification
Requests are tried from both sources: hardware pulses and software triggers. Each source is tried on an idle enabled channel, on a paused channel, on a disabled channel and on a busy channel. These cases tell an accepted request apart from one that is masked, ignored or discarded. Control writes that combine the trigger with activation or with pause show whether the gate uses the values being written or the old register state. A held-low `start_ready` shows that back-pressure keeps the offer without duplicating it. Completion and error reports, sent alone and together and alongside a pause write, separate the stop codes and their priority. Writes with and without the enable and clear bits show how long the interrupt levels persist.

// File: rtl/dmagate_pkg.sv
package dmagate_pkg;

  typedef enum logic [2:0] {
    STOP_RESET  = 3'd0,
    STOP_DONE   = 3'd1,
    STOP_ADDR   = 3'd2,
    STOP_PERIPH = 3'd3,
    STOP_PAUSE  = 3'd4
  } stop_code_e;

  localparam int CTL_EN     = 0;
  localparam int CTL_PAUSE  = 1;
  localparam int CTL_SWTRIG = 2;
  localparam int CTL_CLR    = 3;

  localparam int RD_CODE_LSB = 4;
  localparam int RD_CODE_W   = 3;
  localparam int RD_IEND     = 8;
  localparam int RD_IERR     = 9;
  localparam int RD_MIN_W    = RD_IERR + 1;

endpackage

// File: rtl/dmagate_ctl.sv
module dmagate_ctl
  import dmagate_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stop_evt,
  output logic              en_q,
  output logic              pause_q,
  output logic              en_nxt,
  output logic              pause_nxt,
  output logic              swtrig_pulse,
  output logic              irq_clr,
  output logic              pause_evt
);

  always_comb begin
    if (stop_evt)   en_nxt = 1'b0;
    else if (wr_en) en_nxt = wr_data[CTL_EN];
    else            en_nxt = en_q;
    pause_nxt    = wr_en ? wr_data[CTL_PAUSE] : pause_q;
    swtrig_pulse = wr_en & wr_data[CTL_SWTRIG];
    irq_clr      = wr_en & (wr_data[CTL_EN] | wr_data[CTL_CLR]);
    pause_evt    = en_nxt & pause_nxt & ~(en_q & pause_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pause_q <= 1'b0;
    end else begin
      en_q    <= en_nxt;
      pause_q <= pause_nxt;
    end
  end

  a_r9_stop_disables: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !en_q);

endmodule

// File: rtl/dmagate_gate.sv
module dmagate_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_req,
  input  logic swtrig_pulse,
  input  logic en_nxt,
  input  logic pause_nxt,
  input  logic start_ready,
  input  logic stop_evt,
  output logic start_valid,
  output logic busy_q
);

  logic pending_q;
  logic req_ok;
  logic handshake;

  always_comb begin
    req_ok    = (hw_req | swtrig_pulse) & en_nxt & ~pause_nxt & ~pending_q & ~busy_q;
    handshake = pending_q & start_ready;
  end

  assign start_valid = pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      if (handshake)   pending_q <= 1'b0;
      else if (req_ok) pending_q <= 1'b1;
      if (handshake)     busy_q <= 1'b1;
      else if (stop_evt) busy_q <= 1'b0;
    end
  end

  a_r2_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && !start_ready |=> start_valid);

  a_r13_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !$rose(start_valid));

endmodule

// File: rtl/dmagate_status.sv
module dmagate_status
  import dmagate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy_q,
  input  logic       mv_done,
  input  logic       mv_addr_err,
  input  logic       mv_periph_err,
  input  logic       pause_evt,
  input  logic       irq_clr,
  output logic       stop_evt,
  output stop_code_e code_q,
  output logic       irq_end_q,
  output logic       irq_err_q
);

  logic       set_end;
  logic       set_err;
  stop_code_e code_d;

  always_comb begin
    stop_evt = busy_q & (mv_done | mv_addr_err | mv_periph_err);
    set_err  = busy_q & (mv_addr_err | mv_periph_err);
    set_end  = busy_q & mv_done & ~mv_addr_err & ~mv_periph_err;
    if (busy_q && mv_addr_err)        code_d = STOP_ADDR;
    else if (busy_q && mv_periph_err) code_d = STOP_PERIPH;
    else if (busy_q && mv_done)       code_d = STOP_DONE;
    else if (pause_evt)               code_d = STOP_PAUSE;
    else                              code_d = code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q    <= STOP_RESET;
      irq_end_q <= 1'b0;
      irq_err_q <= 1'b0;
    end else begin
      code_q    <= code_d;
      irq_end_q <= set_end | (irq_end_q & ~irq_clr & ~set_err);
      irq_err_q <= set_err | (irq_err_q & ~irq_clr & ~set_end);
    end
  end

  a_r9_done_code: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && mv_done && !mv_addr_err && !mv_periph_err |=> code_q == STOP_DONE && irq_end_q);

  a_r11_addr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && mv_addr_err |=> code_q == STOP_ADDR && irq_err_q);

  a_r8_pause_silent: assert property (@(posedge clk) disable iff (!rst_n)
    pause_evt && !busy_q |=> code_q == STOP_PAUSE && !$rose(irq_end_q) && !$rose(irq_err_q));

  a_r12_err_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err_q && !irq_clr |=> irq_err_q);

  a_r12_end_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end_q && !irq_clr && !set_err |=> irq_end_q);

endmodule

// File: rtl/dmagate_chan.sv
module dmagate_chan
  import dmagate_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              hw_req,
  output logic              start_valid,
  input  logic              start_ready,
  input  logic              mv_done,
  input  logic              mv_addr_err,
  input  logic              mv_periph_err,
  output logic              irq_end,
  output logic              irq_err
);

  localparam int PAD_W = DATA_W - RD_MIN_W;

  logic       en_q, pause_q, en_nxt, pause_nxt;
  logic       swtrig_pulse, irq_clr, pause_evt;
  logic       stop_evt, busy_q;
  stop_code_e code_q;
  logic       irq_end_q, irq_err_q;

  dmagate_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .stop_evt     (stop_evt),
    .en_q         (en_q),
    .pause_q      (pause_q),
    .en_nxt       (en_nxt),
    .pause_nxt    (pause_nxt),
    .swtrig_pulse (swtrig_pulse),
    .irq_clr      (irq_clr),
    .pause_evt    (pause_evt)
  );

  dmagate_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_req       (hw_req),
    .swtrig_pulse (swtrig_pulse),
    .en_nxt       (en_nxt),
    .pause_nxt    (pause_nxt),
    .start_ready  (start_ready),
    .stop_evt     (stop_evt),
    .start_valid  (start_valid),
    .busy_q       (busy_q)
  );

  dmagate_status u_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy_q        (busy_q),
    .mv_done       (mv_done),
    .mv_addr_err   (mv_addr_err),
    .mv_periph_err (mv_periph_err),
    .pause_evt     (pause_evt),
    .irq_clr       (irq_clr),
    .stop_evt      (stop_evt),
    .code_q        (code_q),
    .irq_end_q     (irq_end_q),
    .irq_err_q     (irq_err_q)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data[DATA_W-1:RD_MIN_W] = '0;
    end
  endgenerate

  assign rd_data[CTL_EN]     = en_q;
  assign rd_data[CTL_PAUSE]  = pause_q;
  assign rd_data[CTL_SWTRIG] = 1'b0;
  assign rd_data[CTL_CLR]    = 1'b0;
  assign rd_data[RD_CODE_LSB +: RD_CODE_W] = code_q;
  assign rd_data[7]          = 1'b0;
  assign rd_data[RD_IEND]    = irq_end_q;
  assign rd_data[RD_IERR]    = irq_err_q;
  assign irq_end = irq_end_q;
  assign irq_err = irq_err_q;

  a_r9_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_end && irq_err));

  a_r3_no_start_paused: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_valid) |-> !pause_q);

  a_r5_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_valid) |-> en_q);

endmodule

// File: tb/tb_dmagate_chan.sv
module tb_dmagate_chan;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DW = 16;
  localparam logic [DW-1:0] EN = 16'h1, PS = 16'h2, SW = 16'h4, CLR = 16'h8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, hw_req = 1'b0, start_ready = 1'b1;
  logic mv_done = 1'b0, mv_addr_err = 1'b0, mv_periph_err = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic start_valid, irq_end, irq_err;

  int checks = 0, failures = 0;
  int exp_q[$];
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmagate_chan #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .hw_req(hw_req), .start_valid(start_valid), .start_ready(start_ready),
    .mv_done(mv_done), .mv_addr_err(mv_addr_err), .mv_periph_err(mv_periph_err),
    .irq_end(irq_end), .irq_err(irq_err)
  );

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic at_neg(); @(negedge clk); endtask

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [DW-1:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_hw(); hw_req = 1'b1; tick(); hw_req = 1'b0; endtask

  task automatic mover(input logic d, input logic a, input logic p);
    mv_done = d; mv_addr_err = a; mv_periph_err = p; tick();
    mv_done = 1'b0; mv_addr_err = 1'b0; mv_periph_err = 1'b0;
  endtask

  task automatic launch(input int tag);
    exp_q.push_back(tag); pulse_hw(); tick();
  endtask

  // Scoreboard monitor: each accepted start must match an expected entry
  always @(negedge clk) begin
    if (rst_n && start_valid && start_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R13 unexpected start actual=1 expected=0");
      end else begin
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    at_neg();
    check("R1 rd_data", rd_data, 0);
    check("R1 irq_end", irq_end, 0);
    check("R1 irq_err", irq_err, 0);
    check("R1 start_valid", start_valid, 0);

    // R2 hardware request with back-pressure
    wr(EN);
    start_ready = 1'b0;
    exp_q.push_back(2);
    pulse_hw();
    at_neg(); check("R2 valid raised", start_valid, 1);
    tick(); tick();
    at_neg(); check("R2 valid held", start_valid, 1);
    tick(); start_ready = 1'b1; tick();
    mover(1, 0, 0);
    at_neg();
    check("R9 code", rd_data[6:4], 1);
    check("R9 enable cleared", rd_data[0], 0);
    check("R9 irq_end", irq_end, 1);
    check("R9 irq_err", irq_err, 0);

    // R12 level interrupt and clearing
    tick(); tick(); at_neg(); check("R12 held", irq_end, 1);
    wr(0); at_neg(); check("R12 plain write keeps", irq_end, 1);
    wr(CLR); at_neg(); check("R12 clear bit", irq_end, 0);

    // R4 software trigger
    wr(EN);
    exp_q.push_back(4);
    wr(EN | SW);
    at_neg(); check("R4 trigger reads 0", rd_data[2], 0);
    check("R4 start offered", start_valid, 1);
    tick();
    mover(1, 0, 0);
    wr(EN); at_neg(); check("R12 enable write clears", irq_end, 0);
    wr(EN); tick(); tick(); at_neg(); check("R4 write 0 no start", start_valid, 0);

    // R5 trigger while disabled
    wr(0); wr(SW);
    at_neg(); check("R5 no start", start_valid, 0); check("R5 still disabled", rd_data[0], 0);
    tick(); tick(); at_neg(); check("R5 no late start", start_valid, 0);

    // R6 trigger with activation
    exp_q.push_back(6);
    wr(EN | SW); tick();
    mover(1, 0, 0);
    at_neg(); check("R6 started", exp_q.size(), 0); check("R6 code", rd_data[6:4], 1);

    // R7 / R8 trigger with pause, activation while paused
    wr(EN | PS | SW);
    at_neg();
    check("R8 code pause", rd_data[6:4], 4);
    check("R8 no irq_end", irq_end, 0);
    check("R8 no irq_err", irq_err, 0);
    check("R7 no start", start_valid, 0);
    wr(EN); tick(); tick(); at_neg(); check("R7 no replay", start_valid, 0);

    // R3 hardware request while paused
    wr(EN | PS); pulse_hw(); tick();
    at_neg(); check("R3 dropped", start_valid, 0);
    wr(EN); tick(); tick(); at_neg(); check("R3 no replay", start_valid, 0);

    // R13 request during transfer
    launch(13);
    pulse_hw(); tick();
    at_neg(); check("R13 busy drop", start_valid, 0);
    mover(1, 0, 0); tick(); tick();
    at_neg(); check("R13 no late start", start_valid, 0);

    // R10 error reports
    wr(EN); launch(10); mover(0, 1, 0);
    at_neg();
    check("R10 addr code", rd_data[6:4], 2);
    check("R10 irq_err", irq_err, 1);
    check("R10 irq_end", irq_end, 0);
    check("R10 enable cleared", rd_data[0], 0);
    wr(EN); at_neg(); check("R12 err cleared", irq_err, 0);
    launch(10); mover(0, 0, 1);
    at_neg(); check("R10 periph code", rd_data[6:4], 3); check("R10 periph irq", irq_err, 1);

    // R11 priority
    wr(EN); launch(11); mover(1, 1, 1);
    at_neg(); check("R11 addr first", rd_data[6:4], 2);
    wr(EN); launch(11); mover(1, 0, 1);
    at_neg(); check("R11 periph over done", rd_data[6:4], 3);
    wr(EN); launch(11);
    wr_en = 1'b1; wr_data = EN | PS; mv_done = 1'b1;
    tick();
    wr_en = 1'b0; wr_data = '0; mv_done = 1'b0;
    at_neg(); check("R11 done over pause", rd_data[6:4], 1); check("R11 irq_end", irq_end, 1);

    tick(); tick(); tick();
    at_neg(); check("R2 all starts seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule